// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer that runs on the system bus clock. Software picks a timeout from a small set of power-of-two divisions of that clock, or turns the watchdog off. To keep the watchdog from firing, software writes a two-byte key to a service register: an arming byte first, then a completing byte. Any other byte written there counts as a failure and triggers a reset at once.

The block has two register addresses, chosen by one select bit:
- The control register holds the rate code, a reset-disable bit and a force-reset bit.
- The service register receives the key and always reads as zero.

A mode input separates normal operation from special (test) operation. In normal mode the control register is write-once and its two reset-control bits are locked. In special mode every field can be written at any time. Also in special mode, a bypass input shortens every timeout by a factor of four.

The only output is a one-cycle reset request. The same pulse restarts the block's own timing state.

Top module: `kwdog_top`

## Requirements
- R1: After reset the control register reads 0x01: rate code 001 in bits 2:0, with bit 6 (reset disable) and bit 7 (force reset) both 0. The service register reads 0x00 at all times.
- R2: Rate code 001 with no service: the first `rst_req` pulse comes after exactly 8192 (2^13) bus clock edges counted from the release of reset.
- R3: Rate codes 001 to 111 select divisions of 2^13, 2^15, 2^17, 2^19, 2^21, 2^22 and 2^23. Code 000 stops the watchdog: no timeout, no key-error reset and no forced reset.
- R4: A service write of 0x55 followed later by a write of 0xAA restarts the timeout count. Other bus writes between the two bytes do not break the sequence.
- R5: A 0xAA write that is not preceded by an armed 0x55 leaves the count running. A repeated 0x55 keeps the sequence armed.
- R6: A service write of any byte other than 0x55 or 0xAA raises `rst_req` in the cycle after the write edge, when the watchdog is on and not disabled.
- R7: `rst_req` is high for one cycle. The pulse clears the count, the armed state and the force bit. When a completing 0xAA lands on the same edge as the expiry, the reset wins.
- R8: In normal mode only the first control write takes effect, and it changes only the rate code. Later control writes are ignored. Bits 6 and 7 cannot be changed in normal mode.
- R9: In special mode all control fields can be written any number of times. A change of rate code restarts the count from zero.
- R10: While bit 6 (reset disable) is set, `rst_req` never rises, whatever the other fields hold.
- R11: Writing bit 7 (force reset) to 1 in special mode, with the watchdog on and not disabled, raises `rst_req` one cycle after the write edge. The bit then reads back as 0.
- R12: With `special_mode` and `test_bypass` both high, every division is a quarter of its normal length (code 001 gives 2048 cycles). In normal mode `test_bypass` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | 1 = special (test) mode, 0 = normal mode |
| test_bypass | input | 1 | In special mode, skips two divider stages |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = service register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the register chosen by `reg_sel` |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The tight case is a completing 0xAA service write that falls on the same clock edge as the expiry of the count. The bench creates it by using a reset pulse as a time anchor, since the pulse leaves the count at zero. It arms the key, then places the 0xAA write exactly on the terminal edge, and expects `rst_req` to rise. It then repeats the case one edge earlier and expects no pulse, followed by a full new period. A cycle-level reference model checks `rst_req` on every cycle. That model also covers the random traffic, in which key errors, forced resets and rate changes can coincide with a timeout.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;
   localparam int          RATE_W   = 3;
   localparam int          EXP_W    = 5;
   localparam logic [7:0]  KEY_ARM  = 8'h55;
   localparam logic [7:0]  KEY_FIRE = 8'hAA;
   localparam int          FORCE_BIT = 7;
   localparam int          HOLD_BIT  = 6;

   typedef struct packed {
      logic              force_rst;
      logic              hold_off;
      logic [RATE_W-1:0] rate;
   } wd_ctl_t;

   function automatic logic [EXP_W-1:0] rate_exp(input logic [RATE_W-1:0] code);
      case (code)
         3'd1:    rate_exp = 5'd13;
         3'd2:    rate_exp = 5'd15;
         3'd3:    rate_exp = 5'd17;
         3'd4:    rate_exp = 5'd19;
         3'd5:    rate_exp = 5'd21;
         3'd6:    rate_exp = 5'd22;
         3'd7:    rate_exp = 5'd23;
         default: rate_exp = 5'd0;
      endcase
   endfunction
endpackage

// File: rtl/kwdog_ctrl.sv
module kwdog_ctrl
   import kwdog_pkg::*;
#(
   parameter logic [RATE_W-1:0] RESET_RATE = 3'd1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              special,
   input  logic              ctl_wr,
   input  logic              wr_force,
   input  logic              wr_hold,
   input  logic [RATE_W-1:0] wr_rate,
   input  logic              fire,
   output wd_ctl_t           ctl,
   output logic              rate_chg
);
   logic locked;
   logic rate_we;

   assign rate_we  = ctl_wr & (special | ~locked);
   assign rate_chg = rate_we && (wr_rate != ctl.rate);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl    <= '{force_rst: 1'b0, hold_off: 1'b0, rate: RESET_RATE};
         locked <= 1'b0;
      end else begin
         if (rate_we)
            ctl.rate <= wr_rate;
         if (ctl_wr && !special)
            locked <= 1'b1;
         if (ctl_wr && special) begin
            ctl.hold_off  <= wr_hold;
            ctl.force_rst <= wr_force;
         end else if (fire) begin
            ctl.force_rst <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/kwdog_key.sv
module kwdog_key
   import kwdog_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       svc_wr,
   input  logic [7:0] wdata,
   input  logic       fire,
   output logic       restart,
   output logic       bad_key
);
   logic armed;
   logic arm_wr;
   logic fin_wr;

   assign arm_wr  = svc_wr && (wdata == KEY_ARM);
   assign fin_wr  = svc_wr && (wdata == KEY_FIRE);
   assign bad_key = svc_wr && !arm_wr && !fin_wr;
   assign restart = fin_wr && armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed <= 1'b0;
      else if (fire)
         armed <= 1'b0;
      else if (arm_wr)
         armed <= 1'b1;
      else if (restart)
         armed <= 1'b0;
   end
endmodule

// File: rtl/kwdog_div.sv
module kwdog_div
   import kwdog_pkg::*;
#(
   parameter int CNT_W         = 24,
   parameter int BYPASS_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             bypass_on,
   input  logic [EXP_W-1:0] expo,
   input  logic             clear,
   output logic             expire
);
   localparam int MAX_EXP = 23;

   generate
      if (CNT_W < MAX_EXP) begin : g_bad_width
         $error("kwdog_div: CNT_W too small for the longest division");
      end
      if (BYPASS_STAGES < 0 || BYPASS_STAGES >= 13) begin : g_bad_bypass
         $error("kwdog_div: BYPASS_STAGES out of range");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] mask;
   logic [EXP_W-1:0] eff;

   generate
      if (BYPASS_STAGES == 0) begin : g_no_bypass
         assign eff = expo;
      end else begin : g_bypass
         assign eff = bypass_on ? (expo - EXP_W'(BYPASS_STAGES)) : expo;
      end
   endgenerate

   assign mask   = (CNT_W'(1) << eff) - CNT_W'(1);
   assign expire = en && ((cnt & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!en || clear)
         cnt <= '0;
      else
         cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/kwdog_top.sv
module kwdog_top
   import kwdog_pkg::*;
#(
   parameter int                CNT_W         = 24,
   parameter int                BYPASS_STAGES = 2,
   parameter logic [RATE_W-1:0] RESET_RATE    = 3'd1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       special_mode,
   input  logic       test_bypass,
   input  logic       wr_en,
   input  logic       reg_sel,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data,
   output logic       rst_req
);
   wd_ctl_t ctl_q;
   logic    svc_wr, ctl_wr, rate_chg, restart, bad_key, expire, en, fire;

   assign svc_wr = wr_en & reg_sel;
   assign ctl_wr = wr_en & ~reg_sel;
   assign en     = (ctl_q.rate != '0);
   assign fire   = en & ~ctl_q.hold_off & (expire | bad_key | ctl_q.force_rst);

   kwdog_ctrl #(.RESET_RATE(RESET_RATE)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .special(special_mode), .ctl_wr(ctl_wr),
      .wr_force(wr_data[FORCE_BIT]), .wr_hold(wr_data[HOLD_BIT]),
      .wr_rate(wr_data[RATE_W-1:0]), .fire(fire), .ctl(ctl_q), .rate_chg(rate_chg)
   );

   kwdog_key u_key (
      .clk(clk), .rst_n(rst_n), .svc_wr(svc_wr), .wdata(wr_data), .fire(fire),
      .restart(restart), .bad_key(bad_key)
   );

   kwdog_div #(.CNT_W(CNT_W), .BYPASS_STAGES(BYPASS_STAGES)) u_div (
      .clk(clk), .rst_n(rst_n), .en(en), .bypass_on(special_mode & test_bypass),
      .expo(rate_exp(ctl_q.rate)), .clear(fire | rate_chg | restart), .expire(expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_req <= 1'b0;
      else        rst_req <= fire;
   end

   assign rd_data = reg_sel ? 8'h00
                            : {ctl_q.force_rst, ctl_q.hold_off, 3'b000, ctl_q.rate};
endmodule

// File: rtl/kwdog_chk.sv
module kwdog_chk
   import kwdog_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       special_mode,
   input logic       wr_en,
   input logic       reg_sel,
   input logic [7:0] wr_data,
   input logic [7:0] rd_data,
   input logic       rst_req,
   input wd_ctl_t    ctl
);
   AST_SVC_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_sel |-> (rd_data == 8'h00)) else $error("service read nonzero"); // R1

   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.rate == 3'd0) |=> !rst_req) else $error("reset while off"); // R3

   AST_BAD_KEY_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel && wr_data != KEY_ARM && wr_data != KEY_FIRE &&
       ctl.rate != 3'd0 && !ctl.hold_off) |=> rst_req) else $error("bad key ignored"); // R6

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req && !wr_en) |=> !rst_req) else $error("reset pulse too long"); // R7

   AST_NORMAL_HOLD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!special_mode && wr_en && !reg_sel) |=> $stable(ctl.hold_off)) else $error("hold changed"); // R8

   AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.hold_off |=> !rst_req) else $error("reset while disabled"); // R10
endmodule

bind kwdog_top kwdog_chk u_chk (
   .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .wr_en(wr_en),
   .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data), .rst_req(rst_req),
   .ctl(ctl_q)
);

// File: tb/sim_kwdog_top.sv
`timescale 1ns/1ps
module sim_kwdog_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       special_mode = 1'b0, test_bypass = 1'b0;
   logic       wr_en = 1'b0, reg_sel = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       rst_req;

   int    checks = 0, errors = 0;
   string tag = "R2";
   logic  mon = 1'b0;

   always #2 clk = ~clk;

   kwdog_top u0 (.clk(clk), .rst_n(rst_n), .special_mode(special_mode),
      .test_bypass(test_bypass), .wr_en(wr_en), .reg_sel(reg_sel),
      .wr_data(wr_data), .rd_data(rd_data), .rst_req(rst_req));

   function automatic int exp_of(input logic [2:0] c);
      case (c)
         3'd1: return 13; 3'd2: return 15; 3'd3: return 17; 3'd4: return 19;
         3'd5: return 21; 3'd6: return 22; 3'd7: return 23;
         default: return 0;
      endcase
   endfunction

   // reference model built from the requirements
   logic [2:0] m_rate;
   logic m_hold, m_force, m_lock, m_armed, m_req;
   int unsigned m_cnt;
   always @(posedge clk or negedge rst_n) begin : model
      int per;
      logic en, svc, ctl, bad, fire, rst_cnt, chg;
      if (!rst_n) begin
         m_rate <= 3'd1; m_hold <= 0; m_force <= 0; m_lock <= 0;
         m_armed <= 0; m_req <= 0; m_cnt <= 0;
      end else begin
         en  = (m_rate != 0);
         per = en ? (1 << (exp_of(m_rate) - ((special_mode && test_bypass) ? 2 : 0))) : 1;
         svc = wr_en && reg_sel;
         ctl = wr_en && !reg_sel;
         bad = svc && wr_data != 8'h55 && wr_data != 8'hAA;
         fire = en && !m_hold && (((m_cnt % per) == per - 1) || bad || m_force);
         chg = ctl && (special_mode || !m_lock) && (wr_data[2:0] != m_rate);
         rst_cnt = svc && wr_data == 8'hAA && m_armed;
         m_req <= fire;
         m_cnt <= (!en || fire || chg || rst_cnt) ? 0 : m_cnt + 1;
         if (fire) m_armed <= 0;
         else if (svc && wr_data == 8'h55) m_armed <= 1;
         else if (rst_cnt) m_armed <= 0;
         if (ctl && special_mode) begin
            m_rate <= wr_data[2:0]; m_hold <= wr_data[6]; m_force <= wr_data[7];
         end else begin
            if (fire) m_force <= 0;
            if (ctl && !m_lock) m_rate <= wr_data[2:0];
         end
         if (ctl && !special_mode) m_lock <= 1;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (rst_n && mon) check(tag, rst_req, m_req);

   task automatic wr(input logic sel, input logic [7:0] d);
      wr_en = 1; reg_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 0; reg_sel = 0;
   endtask

   task automatic rd(input logic sel, input logic [7:0] exp, input string req);
      reg_sel = sel; #0.5;
      check(req, rd_data, exp);
      reg_sel = 0;
   endtask

   task automatic do_reset(input logic sp, input logic bp);
      mon = 0; rst_n = 0; special_mode = sp; test_bypass = bp;
      repeat (3) @(negedge clk);
      rst_n = 1; mon = 1;
   endtask

   task automatic cycles_to_pulse(output int k);
      k = 0;
      do begin @(negedge clk); k++; end while (!rst_req && k < 40000);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      errors++; checks++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int k;
      do_reset(0, 0);
      rd(0, 8'h01, "R1");
      rd(1, 8'h00, "R1");
      tag = "R2";
      cycles_to_pulse(k);
      check("R2", k, 8192);
      @(negedge clk); check("R7", rst_req, 0);

      tag = "R8";
      wr(0, 8'hC1); rd(0, 8'h01, "R8");
      wr(0, 8'h03); rd(0, 8'h01, "R8");

      tag = "R4";
      repeat (6000) @(negedge clk);
      wr(1, 8'h55); wr(0, 8'h02); rd(0, 8'h01, "R4"); wr(1, 8'hAA);
      repeat (6000) @(negedge clk);
      tag = "R5";
      wr(1, 8'hAA);
      repeat (1000) @(negedge clk);
      wr(1, 8'h55); repeat (50) @(negedge clk); wr(1, 8'h55); wr(1, 8'hAA);
      repeat (5000) @(negedge clk);

      // expiry and completing key on the same edge
      tag = "R7";
      cycles_to_pulse(k);
      wr(1, 8'h55);
      repeat (8190) @(negedge clk);
      wr(1, 8'hAA);
      check("R7", rst_req, 1);
      wr(1, 8'h55);
      repeat (8189) @(negedge clk);
      wr(1, 8'hAA);
      check("R7", rst_req, 0);
      cycles_to_pulse(k);
      check("R4", k, 8192);

      tag = "R6";
      wr(1, 8'h3C); check("R6", rst_req, 1);
      @(negedge clk); check("R6", rst_req, 0);

      special_mode = 1;
      tag = "R9";
      wr(0, 8'h02); rd(0, 8'h02, "R9");
      tag = "R3";
      wr(0, 8'h00); rd(0, 8'h00, "R3");
      wr(1, 8'h3C); check("R3", rst_req, 0);
      repeat (10000) @(negedge clk);

      tag = "R12";
      test_bypass = 1;
      wr(0, 8'h01);
      cycles_to_pulse(k);
      check("R12", k, 2048);

      tag = "R10";
      wr(0, 8'h41); rd(0, 8'h41, "R10");
      repeat (5000) @(negedge clk);
      wr(0, 8'hC1); rd(0, 8'hC1, "R10");
      repeat (100) @(negedge clk);
      tag = "R11";
      wr(0, 8'h81); check("R11", rst_req, 0);
      @(negedge clk); check("R11", rst_req, 1);
      rd(0, 8'h01, "R11");

      do_reset(0, 1);
      tag = "R12";
      cycles_to_pulse(k);
      check("R12", k, 8192);

      // random traffic in special mode against the model
      do_reset(1, 1);
      tag = "R9";
      void'($urandom(32'd1234));
      for (int i = 0; i < 30000; i++) begin
         int r;
         r = int'($urandom % 100);
         if (r < 3) wr(1, 8'h55);
         else if (r < 6) wr(1, 8'hAA);
         else if (r == 6) wr(1, 8'($urandom));
         else if (r == 7) wr(0, {($urandom % 8) == 0, ($urandom % 4) == 0, 4'b0000,
                                 2'($urandom % 2 + 1)});
         else @(negedge clk);
      end
      mon = 0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule